// File: doc/BRIEF.md
# Program Memory Long-Write Controller

This block sits between a CPU's table-access path and a one-time-programmable program memory of 16-bit words that the CPU reaches one byte at a time. Writing the low (even) byte of a word only fills half of a holding latch. Writing the high (odd) byte fills the other half. When a sticky long-write enable bit is set and the programming-voltage flag is high, that write also starts a long write, which burns the latched word into the array word chosen by the address of the high-byte write.

During a long write the block raises `halt` so that the CPU stops executing. Clocks and peripherals keep running. The long write ends when an enabled interrupt arrives (`irq_end`) or when a reset occurs. A cycle counter checks that programming lasted at least the minimum time. A write that ends too early, or that loses the programming voltage, leaves the array unchanged and sets a sticky incomplete flag.

Programming can only clear bits: the stored word becomes the bitwise AND of itself and the latch. A power-on reset sets every word to all ones. Table reads return the stored byte for the current address in the same cycle, so software can verify a write.

Top module: `prog_mem_lw_ctrl`

## Requirements
- R1: A table write with address bit 0 = 0 loads the low byte of the holding latch only. It leaves the array unchanged and does not raise `halt`.
- R2: A table write with address bit 0 = 1, while `armed` is 1 and `vpp_ok` is 1, starts a long write. `halt` is 1 from the clock edge that takes the write.
- R3: A table write with address bit 0 = 1 while `armed` is 0 is a short write. It updates the latch high byte only, leaves the array unchanged and does not raise `halt`.
- R4: `armed` becomes 1 at the edge after `arm_set` is sampled high. It then stays 1 until `por_n` or `mclr_n` goes low. No input clears it.
- R5: A high-byte write while `vpp_ok` is 0 is a short write. `halt` stays 0 and `burn_short` is not set.
- R6: A long write ends at the edge that samples `irq_end` high, and `halt` is 0 after that edge. The target word is address bits [ADDR_W:1] of the high-byte write.
- R7: The write commits only if `halt` has been high for at least MIN_PROG_CYC edges, counting the edge that samples `irq_end`. When it commits, the target word becomes its old value ANDed with the latch ({high byte, low byte}).
- R8: A long write that ends early, or that sees `vpp_ok` low while `halt` is high, leaves the array unchanged, drops `halt` and sets `burn_short`. `burn_short` stays 1 until a reset.
- R9: `tbl_rdata` is the stored byte of word tbl_addr[ADDR_W:1]: the high byte when tbl_addr[0] = 1, the low byte when it is 0. It is combinational from the address.
- R10: Table writes sampled while `halt` is high change neither latch byte.
- R11: `mclr_n` low ends any long write without a commit and clears `halt`, `armed`, `burn_short` and the latch, but keeps the array. `por_n` low does the same and also sets every array word to 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, async assert, sync release |
| mclr_n | input | 1 | External pin reset, active low, async assert, sync release |
| tbl_wr | input | 1 | Table write strobe |
| tbl_addr | input | ADDR_W+1 | Byte address; bit 0 selects the high byte |
| tbl_wdata | input | 8 | Table write data |
| arm_set | input | 1 | Sets the sticky long-write enable |
| vpp_ok | input | 1 | Programming voltage present |
| irq_end | input | 1 | Enabled interrupt that terminates a long write |
| tbl_rdata | output | 8 | Table read data |
| halt | output | 1 | Halts CPU execution during a long write |
| armed | output | 1 | Long-write enable state |
| burn_short | output | 1 | Sticky incomplete-programming flag |

## Verification
The assertions assume that both resets are released in step with the clock, and that the CPU issues no table writes while `halt` is high except when that case is being tested on purpose. They also assume that `irq_end` and `vpp_ok` are levels sampled at the clock edge. The stimulus changes every input a fixed delay after a rising edge, so each value is stable for a whole cycle. It holds `irq_end` for exactly one cycle, and it raises or drops `vpp_ok` only between table writes. Interrupt timing is placed exactly on and one edge short of the minimum programming time.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    LW_IDLE = 1'b0,
    LW_BURN = 1'b1
  } lw_state_e;
endpackage

// File: rtl/lw_latch.sv
module lw_latch
  import lw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              hold,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              load;

  assign load = wr & ~hold;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load) begin
      if (sel_hi) hi_d = wdata;
      else        lo_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '1;
      hi_q <= '1;
    end else if (load) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign word = {hi_q, lo_q};

  // R10: latch is frozen while a long write is under way
  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(word));
endmodule

// File: rtl/lw_sequencer.sv
module lw_sequencer
  import lw_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int MIN_PROG_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              arm_set,
  input  logic              vpp_ok,
  input  logic              irq_end,
  output logic              busy,
  output logic              armed,
  output logic              short_flag,
  output logic              commit,
  output logic [ADDR_W-1:0] tgt
);
  localparam int CNT_W = (MIN_PROG_CYC > 1) ? $clog2(MIN_PROG_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PROG_CYC - 1);

  lw_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              arm_q, arm_d;
  logic              sht_q, sht_d;
  logic              long_enough;

  assign long_enough = (cnt_q >= LAST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    arm_d  = arm_q | arm_set;
    sht_d  = sht_q;
    commit = 1'b0;
    unique case (st_q)
      LW_IDLE: begin
        if (wr_hi && arm_q && vpp_ok) begin
          st_d  = LW_BURN;
          tgt_d = word_addr;
          cnt_d = '0;
        end
      end
      LW_BURN: begin
        if (!vpp_ok) begin
          st_d  = LW_IDLE;
          sht_d = 1'b1;
        end else if (irq_end) begin
          st_d = LW_IDLE;
          if (long_enough) commit = 1'b1;
          else             sht_d  = 1'b1;
        end else if (!long_enough) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = LW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LW_IDLE;
      cnt_q <= '0;
      tgt_q <= '0;
      arm_q <= 1'b0;
      sht_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
      arm_q <= arm_d;
      sht_q <= sht_d;
    end
  end

  assign busy       = (st_q == LW_BURN);
  assign armed      = arm_q;
  assign short_flag = sht_q;
  assign tgt        = tgt_q;

  // R2: halting requires the enable bit
  p_halt_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> armed);
  // R2: a long write starts only from a high-byte write with voltage present
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_hi && vpp_ok));
  // R4: enable bit is sticky
  p_arm_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  // R6: an interrupt ends the long write
  p_halt_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irq_end) |=> !busy);
  // R8: incomplete flag is sticky
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_flag |=> short_flag);
endmodule

// File: rtl/otp_array.sv
module otp_array
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] burn_val;

  assign burn_val = mem_q[waddr] & wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (prog_en) begin
      mem_q[waddr] <= burn_val;
    end
  end

  assign rdata = mem_q[raddr];

  // R7: programming only clears bits
  p_and_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((mem_q[$past(waddr)] & ~$past(mem_q[waddr])) == '0));
endmodule

// File: rtl/prog_mem_lw_ctrl.sv
module prog_mem_lw_ctrl
  import lw_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int MIN_PROG_CYC = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mclr_n,
  input  logic              tbl_wr,
  input  logic [ADDR_W:0]   tbl_addr,
  input  logic [BYTE_W-1:0] tbl_wdata,
  input  logic              arm_set,
  input  logic              vpp_ok,
  input  logic              irq_end,
  output logic [BYTE_W-1:0] tbl_rdata,
  output logic              halt,
  output logic              armed,
  output logic              burn_short
);
  logic              ctl_rst_n;
  logic              sel_hi;
  logic [ADDR_W-1:0] word_addr;
  logic [WORD_W-1:0] latch_word;
  logic [WORD_W-1:0] rd_word;
  logic              commit;
  logic [ADDR_W-1:0] tgt;
  logic              busy;

  assign ctl_rst_n = por_n & mclr_n;
  assign sel_hi    = tbl_addr[0];
  assign word_addr = tbl_addr[ADDR_W:1];

  lw_latch u_latch (
    .clk   (clk),
    .rst_n (ctl_rst_n),
    .wr    (tbl_wr),
    .sel_hi(sel_hi),
    .wdata (tbl_wdata),
    .hold  (busy),
    .word  (latch_word)
  );

  lw_sequencer #(
    .ADDR_W      (ADDR_W),
    .MIN_PROG_CYC(MIN_PROG_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (ctl_rst_n),
    .wr_hi     (tbl_wr & sel_hi),
    .word_addr (word_addr),
    .arm_set   (arm_set),
    .vpp_ok    (vpp_ok),
    .irq_end   (irq_end),
    .busy      (busy),
    .armed     (armed),
    .short_flag(burn_short),
    .commit    (commit),
    .tgt       (tgt)
  );

  otp_array #(
    .ADDR_W(ADDR_W)
  ) u_mem (
    .clk    (clk),
    .rst_n  (por_n),
    .prog_en(commit),
    .waddr  (tgt),
    .wdata  (latch_word),
    .raddr  (word_addr),
    .rdata  (rd_word)
  );

  assign tbl_rdata = sel_hi ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
  assign halt      = busy;
endmodule

// File: tb/prog_mem_lw_ctrl_test.sv
`timescale 1ns/1ps
module prog_mem_lw_ctrl_test;
  localparam int AW  = 6;
  localparam int MIN = 8;
  localparam int DEP = 1 << AW;

  logic          clk = 1'b0;
  logic          por_n, mclr_n, tbl_wr, arm_set, vpp_ok, irq_end;
  logic [AW:0]   tbl_addr;
  logic [7:0]    tbl_wdata;
  logic [7:0]    tbl_rdata;
  logic          halt, armed, burn_short;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference model state
  logic [15:0] m_mem [DEP];
  logic [15:0] m_lat;
  logic        m_arm, m_prog, m_short;
  int          m_cnt;
  int          m_tgt;

  always #4 clk = ~clk;

  prog_mem_lw_ctrl #(.ADDR_W(AW), .MIN_PROG_CYC(MIN)) uut (
    .clk(clk), .por_n(por_n), .mclr_n(mclr_n), .tbl_wr(tbl_wr),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .arm_set(arm_set),
    .vpp_ok(vpp_ok), .irq_end(irq_end), .tbl_rdata(tbl_rdata),
    .halt(halt), .armed(armed), .burn_short(burn_short)
  );

  always @(posedge clk) begin
    bit old_arm;
    if (!por_n) begin
      for (int i = 0; i < DEP; i++) m_mem[i] = 16'hFFFF;
      m_lat = 16'hFFFF; m_arm = 0; m_prog = 0; m_short = 0; m_cnt = 0;
    end else if (!mclr_n) begin
      m_lat = 16'hFFFF; m_arm = 0; m_prog = 0; m_short = 0; m_cnt = 0;
    end else begin
      old_arm = m_arm;
      if (arm_set) m_arm = 1;
      if (m_prog) begin
        if (!vpp_ok) begin
          m_prog = 0; m_short = 1;
        end else if (irq_end) begin
          if (m_cnt + 1 >= MIN) m_mem[m_tgt] = m_mem[m_tgt] & m_lat;
          else m_short = 1;
          m_prog = 0;
        end else m_cnt++;
      end else if (tbl_wr) begin
        if (!tbl_addr[0]) m_lat[7:0] = tbl_wdata;
        else begin
          m_lat[15:8] = tbl_wdata;
          if (old_arm && vpp_ok) begin
            m_prog = 1; m_cnt = 0; m_tgt = int'(tbl_addr[AW:1]);
          end
        end
      end
    end
  end

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_rd();
    logic [15:0] w;
    w = m_mem[int'(tbl_addr[AW:1])];
    return tbl_addr[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
    chk("R2 halt per cycle", {15'd0, halt}, {15'd0, m_prog});
    chk("R4 armed per cycle", {15'd0, armed}, {15'd0, m_arm});
    chk("R8 flag per cycle", {15'd0, burn_short}, {15'd0, m_short});
    if (por_n) chk("R9 rdata per cycle", {8'd0, tbl_rdata}, {8'd0, m_rd()});
  endtask

  task automatic wr_byte(int a, logic [7:0] d);
    tbl_wr = 1; tbl_addr = (AW+1)'(a); tbl_wdata = d;
    step();
    tbl_wr = 0;
  endtask

  task automatic rd_word(int w, string req, logic [15:0] exp);
    tbl_addr = (AW+1)'(2*w);     #1; chk(req, {8'd0, tbl_rdata}, {8'd0, exp[7:0]});
    tbl_addr = (AW+1)'(2*w + 1); #1; chk(req, {8'd0, tbl_rdata}, {8'd0, exp[15:8]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    por_n = 0; mclr_n = 0; tbl_wr = 0; arm_set = 0; vpp_ok = 0; irq_end = 0;
    tbl_addr = '0; tbl_wdata = '0;
    repeat (3) step();
    por_n = 1; mclr_n = 1;
    step();
    chk("R11 reset outputs", {13'd0, halt, armed, burn_short}, 16'd0);
    rd_word(5, "R11 erased after power-on", 16'hFFFF);

    // R1 and R3: short writes without arming
    vpp_ok = 1;
    wr_byte(6, 8'h12);
    chk("R1 no halt on even write", {15'd0, halt}, 16'd0);
    wr_byte(7, 8'h34);
    step();
    chk("R3 no halt unarmed", {15'd0, halt}, 16'd0);
    rd_word(3, "R3 memory unchanged", 16'hFFFF);

    // R4 arm
    arm_set = 1; step(); arm_set = 0; step();
    chk("R4 armed sticky", {15'd0, armed}, 16'd1);

    // R5 no voltage
    vpp_ok = 0;
    wr_byte(7, 8'h34);
    step();
    chk("R5 no halt without vpp", {14'd0, halt, burn_short}, 16'd0);
    vpp_ok = 1;

    // R2, R6, R7, R10: exact minimum time
    wr_byte(6, 8'h5A);
    wr_byte(7, 8'h3C);
    chk("R2 halt after armed msb", {15'd0, halt}, 16'd1);
    wr_byte(6, 8'h00);               // ignored, R10
    repeat (MIN - 2) step();
    irq_end = 1; step(); irq_end = 0;
    chk("R6 halt released", {15'd0, halt}, 16'd0);
    chk("R7 flag clear on full time", {15'd0, burn_short}, 16'd0);
    rd_word(3, "R10 write during halt ignored", 16'h3C5A);

    // R7 AND behaviour
    wr_byte(6, 8'hF0);
    wr_byte(7, 8'hFF);
    repeat (MIN - 1) step();
    irq_end = 1; step(); irq_end = 0;
    rd_word(3, "R7 bitwise AND burn", 16'h3C50);

    // R8 one edge short
    wr_byte(2, 8'h00);
    wr_byte(3, 8'h00);
    repeat (MIN - 2) step();
    irq_end = 1; step(); irq_end = 0;
    chk("R8 early end sets flag", {14'd0, halt, burn_short}, 16'd1);
    rd_word(1, "R8 early end leaves memory", 16'hFFFF);

    // R8 voltage loss
    wr_byte(4, 8'h00);
    wr_byte(5, 8'h00);
    step();
    vpp_ok = 0; step();
    chk("R8 vpp loss ends halt", {15'd0, halt}, 16'd0);
    vpp_ok = 1;
    repeat (MIN) step();
    rd_word(2, "R8 vpp loss leaves memory", 16'hFFFF);
    chk("R8 flag still set", {15'd0, burn_short}, 16'd1);

    // R11 pin reset during a long write
    wr_byte(8, 8'h00);
    wr_byte(9, 8'h00);
    repeat (MIN) step();
    mclr_n = 0; step();
    chk("R11 pin reset clears", {13'd0, halt, armed, burn_short}, 16'd0);
    mclr_n = 1; step();
    rd_word(4, "R11 no commit on pin reset", 16'hFFFF);
    rd_word(3, "R11 pin reset keeps memory", 16'h3C50);

    // R3 after pin reset: unarmed msb write is short
    wr_byte(7, 8'h00);
    step();
    chk("R3 unarmed after pin reset", {15'd0, halt}, 16'd0);

    // R11 power-on reset erases
    por_n = 0; step(); por_n = 1; step();
    rd_word(3, "R11 power-on erases", 16'hFFFF);

    finish_run();
  end
endmodule